// File: doc/BRIEF.md
# Y-Extended Saturating Integer Divider

This block is a multi-cycle integer divider. It is meant to sit beside an execution pipeline. A caller presents two operands and a set of mode bits, pulses `start`, and waits for a one-cycle `done`. It can work in two sizes.

In the half-width size, the dividend is double the divisor's width. Its upper half comes from a separate Y register input and its lower half from the low half of `rs1`. The quotient is then clamped to the half width: an unsigned result that is too large becomes all ones in the low half, and a signed result that is out of range becomes the largest positive or the most negative half-width value. In the full-width size, `rs1` is divided by the full second operand and Y plays no part.

The second operand is either `rs2` or a sign-extended immediate. Signed division works on magnitudes and rounds toward zero, and the remainder is dropped. A zero divisor produces an exception pulse instead of a result. When asked to, the block also produces negative, zero, overflow and carry flags that describe the final value.

Top module: `ydiv_top`

## Requirements
- R1: The second operand is `imm` sign-extended from IMM_W bits to DW bits when `use_imm` is 1, and `rs2` otherwise. In half-width mode (`wide`=0) the dividend is {`y_in`, `rs1`[HW-1:0]} (HW = DW/2) and the divisor is bits [HW-1:0] of the second operand. The divisor is zero-extended when unsigned and sign-extended when signed. The upper bits of `rs1` and of the second operand have no effect.
- R2: If the divisor selected at a `start` is zero, `done` and `div_zero` are 1 in the very next cycle, and `busy`, `result_we` and `flags_we` are 0 in that cycle.
- R3: In unsigned half-width mode, a quotient with any nonzero bit at or above bit HW gives `quotient` = HW zeros followed by HW ones.
- R4: In signed half-width mode, a positive quotient above 2^(HW-1)-1 gives `quotient` = 2^(HW-1)-1, with the upper half zero.
- R5: In signed half-width mode, a negative quotient below -2^(HW-1) gives `quotient` = -2^(HW-1), sign-extended to DW bits.
- R6: `flag_v` is 1 exactly when R3, R4 or R5 clamped the result. `flags_we` pulses together with `result_we` only when `set_flags` was 1 at `start`.
- R7: In full-width mode (`wide`=1), `quotient` is `rs1` divided by the full second operand, and `y_in` has no effect.
- R8: For a nonzero divisor, `busy` is 1 for exactly DW+1 cycles starting in the cycle after `start`. `done` and `result_we` are 1 for exactly one cycle, the cycle in which `busy` first returns to 0.
- R9: Signed division rounds toward zero. The sign of the quotient is the XOR of the operand signs. A non-clamped half-width signed result is sign-extended to DW bits, and an unsigned one is zero-extended.
- R10: `flag_c` is 0. `flag_n` is bit HW-1 of the final `quotient`. `flag_z` is 1 when bits [HW-1:0] of the final `quotient` are all zero.
- R11: In signed full-width mode, the most negative dividend divided by -1 returns the most negative value, with `div_zero` 0 and `flag_v` 0.
- R12: A `start` received while `busy` is 1 is ignored. The running division completes with its original operands, and no extra `done` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division with the operands present this cycle |
| rs1 | input | DW | First source operand (dividend, or its low half) |
| rs2 | input | DW | Second source operand (divisor) |
| imm | input | IMM_W | Immediate divisor, sign-extended |
| use_imm | input | 1 | Select `imm` instead of `rs2` |
| y_in | input | DW/2 | Upper half of the dividend in half-width mode |
| is_signed | input | 1 | Treat operands as two's complement |
| wide | input | 1 | Full-width mode; 0 selects half-width with Y |
| set_flags | input | 1 | Request flag write-back for this division |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result_we | output | 1 | `quotient` is valid this cycle |
| div_zero | output | 1 | Division-by-zero exception pulse |
| quotient | output | DW | Final, possibly clamped, quotient |
| flags_we | output | 1 | Flags are valid and should be written |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (clamping occurred) |
| flag_c | output | 1 | Carry flag, always cleared |

## Verification
The hardest cases to reach from the ports are the signed clamping boundaries. A half-width negative quotient of exactly -2^(HW-1) must pass through unchanged, while one step further must clamp. Reaching these needs particular pairings of a large Y value and a small negative divisor, which random operands seldom produce. The bench therefore uses an 8-bit configuration and sweeps every Y value, every low dividend half and every divisor, in both signed and unsigned modes. This covers every boundary, both clamp directions and every zero divisor. Separate sweeps cover the full-width quotients, including most-negative divided by -1, and every immediate value.

// File: rtl/ydiv_pkg.sv
package ydiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } ydiv_state_e;

endpackage

// File: rtl/ydiv_operands.sv
module ydiv_operands #(
   parameter int DW    = 64,
   parameter int IMM_W = 13
) (
   input  logic [DW-1:0]    rs1,
   input  logic [DW-1:0]    rs2,
   input  logic [IMM_W-1:0] imm,
   input  logic             use_imm,
   input  logic [DW/2-1:0]  y_in,
   input  logic             is_signed,
   input  logic             wide,
   output logic [DW-1:0]    mag_a,
   output logic [DW-1:0]    mag_b,
   output logic             neg_q,
   output logic             zero_div
);
   localparam int HW = DW / 2;

   logic [DW-1:0] imm_ext;
   logic [DW-1:0] op2;
   logic [DW-1:0] dvd;
   logic [DW-1:0] dvs;
   logic          sign_a;
   logic          sign_b;

   // Immediate widening: variant chosen by the immediate width.
   generate
      if (IMM_W < DW) begin : g_imm_sext
         assign imm_ext = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
      end else begin : g_imm_full
         assign imm_ext = imm[DW-1:0];
      end
   endgenerate

   assign op2 = use_imm ? imm_ext : rs2;

   always_comb begin
      if (wide) begin
         dvd = rs1;
         dvs = op2;
      end else begin
         dvd = {y_in, rs1[HW-1:0]};
         if (is_signed) dvs = {{HW{op2[HW-1]}}, op2[HW-1:0]};
         else           dvs = {{HW{1'b0}}, op2[HW-1:0]};
      end
   end

   assign sign_a   = is_signed & dvd[DW-1];
   assign sign_b   = is_signed & dvs[DW-1];
   assign mag_a    = sign_a ? ({DW{1'b0}} - dvd) : dvd;
   assign mag_b    = sign_b ? ({DW{1'b0}} - dvs) : dvs;
   assign neg_q    = sign_a ^ sign_b;
   assign zero_div = (dvs == {DW{1'b0}});

endmodule

// File: rtl/ydiv_core.sv
module ydiv_core #(
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [DW-1:0] dividend,
   input  logic [DW-1:0] divisor,
   output logic [DW-1:0] quo
);
   logic [DW-1:0] rem_q;
   logic [DW-1:0] dvs_q;
   logic [DW:0]   shifted;
   logic [DW:0]   trial;

   // One restoring step: bring in the next dividend bit, try to subtract.
   assign shifted = {rem_q, quo[DW-1]};
   assign trial   = shifted - {1'b0, dvs_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         dvs_q <= '0;
         quo   <= '0;
      end else if (load) begin
         rem_q <= '0;
         dvs_q <= divisor;
         quo   <= dividend;
      end else if (step) begin
         if (!trial[DW]) begin
            rem_q <= trial[DW-1:0];
            quo   <= {quo[DW-2:0], 1'b1};
         end else begin
            rem_q <= shifted[DW-1:0];
            quo   <= {quo[DW-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/ydiv_fix.sv
module ydiv_fix #(
   parameter int DW = 64
) (
   input  logic [DW-1:0] qmag,
   input  logic          neg,
   input  logic          is_signed,
   input  logic          wide,
   output logic [DW-1:0] result,
   output logic          sat,
   output logic          fn,
   output logic          fz
);
   localparam int HW = DW / 2;
   localparam logic [DW-1:0] SAT_U    = {{HW{1'b0}}, {HW{1'b1}}};
   localparam logic [DW-1:0] SAT_P    = SAT_U >> 1;
   localparam logic [DW-1:0] SAT_N    = ~SAT_P;
   localparam logic [DW-1:0] HALF_MIN = {{(DW-1){1'b0}}, 1'b1} << (HW-1);

   logic [DW-1:0] qneg;
   logic          upper_nz;
   logic          upper_sgn_nz;

   assign qneg         = {DW{1'b0}} - qmag;
   assign upper_nz     = |qmag[DW-1:HW];
   assign upper_sgn_nz = |qmag[DW-1:HW-1];

   always_comb begin
      sat    = 1'b0;
      result = qmag;
      if (wide) begin
         result = neg ? qneg : qmag;
      end else if (!is_signed) begin
         sat    = upper_nz;
         result = upper_nz ? SAT_U : qmag;
      end else if (!neg) begin
         sat    = upper_sgn_nz;
         result = upper_sgn_nz ? SAT_P : qmag;
      end else begin
         sat    = (qmag > HALF_MIN);
         result = sat ? SAT_N : qneg;
      end
   end

   assign fn = result[HW-1];
   assign fz = (result[HW-1:0] == {HW{1'b0}});

endmodule

// File: rtl/ydiv_top.sv
module ydiv_top
   import ydiv_pkg::*;
#(
   parameter int DW    = 64,
   parameter int IMM_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DW-1:0]    rs1,
   input  logic [DW-1:0]    rs2,
   input  logic [IMM_W-1:0] imm,
   input  logic             use_imm,
   input  logic [DW/2-1:0]  y_in,
   input  logic             is_signed,
   input  logic             wide,
   input  logic             set_flags,
   output logic             busy,
   output logic             done,
   output logic             result_we,
   output logic             div_zero,
   output logic [DW-1:0]    quotient,
   output logic             flags_we,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_v,
   output logic             flag_c
);
   localparam int HW = DW / 2;
   localparam int CW = $clog2(DW + 1);

   generate
      if (DW < 8 || (DW % 2) != 0) begin : g_bad_dw
         $error("ydiv_top: DW must be even and at least 8");
      end
      if (IMM_W < 2 || IMM_W > DW) begin : g_bad_imm
         $error("ydiv_top: IMM_W must lie in 2..DW");
      end
   endgenerate

   ydiv_state_e   state_q;
   logic [CW-1:0] cnt_q;
   logic          sgn_q;
   logic          wide_q;
   logic          setf_q;
   logic          neg_q;

   logic [DW-1:0] mag_a;
   logic [DW-1:0] mag_b;
   logic          neg_c;
   logic          zero_c;
   logic [DW-1:0] qmag;
   logic [DW-1:0] fix_res;
   logic          fix_sat;
   logic          fix_n;
   logic          fix_z;
   logic          accept;
   logic          launch;
   logic          stepping;

   ydiv_operands #(.DW(DW), .IMM_W(IMM_W)) u_operands (
      .rs1       (rs1),
      .rs2       (rs2),
      .imm       (imm),
      .use_imm   (use_imm),
      .y_in      (y_in),
      .is_signed (is_signed),
      .wide      (wide),
      .mag_a     (mag_a),
      .mag_b     (mag_b),
      .neg_q     (neg_c),
      .zero_div  (zero_c)
   );

   assign accept   = start && (state_q == ST_IDLE);
   assign launch   = accept && !zero_c;
   assign stepping = (state_q == ST_RUN);

   ydiv_core #(.DW(DW)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (launch),
      .step     (stepping),
      .dividend (mag_a),
      .divisor  (mag_b),
      .quo      (qmag)
   );

   ydiv_fix #(.DW(DW)) u_fix (
      .qmag      (qmag),
      .neg       (neg_q),
      .is_signed (sgn_q),
      .wide      (wide_q),
      .result    (fix_res),
      .sat       (fix_sat),
      .fn        (fix_n),
      .fz        (fix_z)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         sgn_q     <= 1'b0;
         wide_q    <= 1'b0;
         setf_q    <= 1'b0;
         neg_q     <= 1'b0;
         done      <= 1'b0;
         result_we <= 1'b0;
         div_zero  <= 1'b0;
         flags_we  <= 1'b0;
         quotient  <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_v    <= 1'b0;
         flag_c    <= 1'b0;
      end else begin
         done      <= 1'b0;
         result_we <= 1'b0;
         div_zero  <= 1'b0;
         flags_we  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (zero_c) begin
                     done     <= 1'b1;
                     div_zero <= 1'b1;
                  end else begin
                     state_q <= ST_RUN;
                     cnt_q   <= CW'(DW);
                     sgn_q   <= is_signed;
                     wide_q  <= wide;
                     setf_q  <= set_flags;
                     neg_q   <= neg_c;
                  end
               end
            end
            ST_RUN: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CW'(1)) state_q <= ST_FIN;
            end
            ST_FIN: begin
               state_q   <= ST_IDLE;
               quotient  <= fix_res;
               flag_n    <= fix_n;
               flag_z    <= fix_z;
               flag_v    <= fix_sat;
               flag_c    <= 1'b0;
               done      <= 1'b1;
               result_we <= 1'b1;
               flags_we  <= setf_q;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/ydiv_chk.sv
module ydiv_chk #(
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          result_we,
   input logic          div_zero,
   input logic          flags_we,
   input logic          flag_v,
   input logic [DW-1:0] quotient
);
   localparam int HW = DW / 2;
   localparam logic [DW-1:0] SAT_U = {{HW{1'b0}}, {HW{1'b1}}};
   localparam logic [DW-1:0] SAT_P = SAT_U >> 1;
   localparam logic [DW-1:0] SAT_N = ~SAT_P;

   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_we |=> !result_we);

   // R8
   we_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_we |-> (done && $past(busy)));

   // R2
   dz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero |-> (done && !busy && !result_we && !flags_we));

   // R6
   flags_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> result_we);

   // R3 R4 R5
   sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (result_we && flag_v) |-> (quotient == SAT_U || quotient == SAT_P || quotient == SAT_N));

endmodule

bind ydiv_top ydiv_chk #(.DW(DW)) u_ydiv_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .result_we (result_we),
   .div_zero  (div_zero),
   .flags_we  (flags_we),
   .flag_v    (flag_v),
   .quotient  (quotient)
);

// File: tb/ydiv_top_bench.sv
module ydiv_top_bench;
   localparam int DW    = 8;
   localparam int HW    = 4;
   localparam int IMM_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [DW-1:0]    rs1 = '0;
   logic [DW-1:0]    rs2 = '0;
   logic [IMM_W-1:0] imm = '0;
   logic             use_imm = 1'b0;
   logic [HW-1:0]    y_in = '0;
   logic             is_signed = 1'b0;
   logic             wide = 1'b0;
   logic             set_flags = 1'b0;
   logic             busy, done, result_we, div_zero, flags_we;
   logic             flag_n, flag_z, flag_v, flag_c;
   logic [DW-1:0]    quotient;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ydiv_top #(.DW(DW), .IMM_W(IMM_W)) u_ydiv_top (
      .clk(clk), .rst_n(rst_n), .start(start), .rs1(rs1), .rs2(rs2),
      .imm(imm), .use_imm(use_imm), .y_in(y_in), .is_signed(is_signed),
      .wide(wide), .set_flags(set_flags), .busy(busy), .done(done),
      .result_we(result_we), .div_zero(div_zero), .quotient(quotient),
      .flags_we(flags_we), .flag_n(flag_n), .flag_z(flag_z),
      .flag_v(flag_v), .flag_c(flag_c)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Arithmetic reference from the requirements.
   task automatic model(input logic [7:0] r1, input logic [7:0] r2,
                        input logic [4:0] im, input logic ui, input logic [3:0] yy,
                        input logic sg, input logic wd,
                        output logic [7:0] q, output logic v, output logic dz,
                        output string tag);
      int a, b, qi;
      logic [7:0] op2;
      logic [7:0] dvd;
      op2 = ui ? {{3{im[4]}}, im} : r2;
      q = 8'h00; v = 1'b0; tag = "R1";
      if (wd) begin
         if (sg) begin a = $signed(r1); b = $signed(op2); end
         else    begin a = r1;          b = op2;          end
      end else begin
         dvd = {yy, r1[3:0]};
         if (sg) begin a = $signed(dvd); b = $signed(op2[3:0]); end
         else    begin a = dvd;          b = op2[3:0];          end
      end
      dz = (b == 0);
      if (dz) begin tag = "R2"; return; end
      qi = a / b;
      if (wd) begin
         q = qi[7:0];
         tag = (sg && a == -128 && b == -1) ? "R11" : "R7";
      end else if (!sg) begin
         if (qi > 15) begin q = 8'h0F; v = 1'b1; tag = "R3"; end
         else q = qi[7:0];
      end else begin
         tag = "R9";
         if (qi > 7)       begin q = 8'h07; v = 1'b1; tag = "R4"; end
         else if (qi < -8) begin q = 8'hF8; v = 1'b1; tag = "R5"; end
         else q = qi[7:0];
      end
   endtask

   task automatic run_op(input logic [7:0] r1, input logic [7:0] r2,
                         input logic [4:0] im, input logic ui, input logic [3:0] yy,
                         input logic sg, input logic wd, input logic sf,
                         input bit interfere);
      logic [7:0] eq;
      logic ev, edz;
      string tag;
      int cyc;
      model(r1, r2, im, ui, yy, sg, wd, eq, ev, edz, tag);
      @(negedge clk);
      rs1 = r1; rs2 = r2; imm = im; use_imm = ui; y_in = yy;
      is_signed = sg; wide = wd; set_flags = sf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      if (edz) begin
         chk(done && div_zero && !busy && !result_we && !flags_we, "R2",
             "zero divisor pulse", {11'd0, done, div_zero, busy, result_we, flags_we},
             16'h0018);
      end else begin
         while (!done && cyc < 100) begin
            if (interfere && cyc == 3) begin
               start = 1'b1; rs1 = ~r1; y_in = ~yy; rs2 = 8'h00; use_imm = 1'b0;
            end else begin
               start = 1'b0;
            end
            @(negedge clk);
            cyc++;
         end
         start = 1'b0;
         chk(cyc == DW + 2, "R8", "busy cycles before done", 16'(cyc - 1), 16'(DW + 1));
         chk(quotient == eq && result_we && !div_zero, interfere ? "R12" : tag,
             "quotient", {7'd0, result_we, quotient}, {7'd0, 1'b1, eq});
         chk(flag_v == ev, "R6", "overflow flag", {15'd0, flag_v}, {15'd0, ev});
         chk(flags_we == sf, "R6", "flag write enable", {15'd0, flags_we}, {15'd0, sf});
         chk({flag_n, flag_z, flag_c} == {eq[3], eq[3:0] == 4'h0, 1'b0}, "R10",
             "n z c", {13'd0, flag_n, flag_z, flag_c},
             {13'd0, eq[3], eq[3:0] == 4'h0, 1'b0});
      end
      @(negedge clk);
      chk(!done && !busy, interfere ? "R12" : "R8", "no further done",
          {14'd0, done, busy}, 16'h0000);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 195000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] dlist [8];
      dlist = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h80, 8'hFF, 8'hFD};
      repeat (3) @(negedge clk);
      chk(!busy && !done && !result_we && !div_zero && !flags_we && quotient == 8'h00,
          "R8", "reset state", {3'd0, busy, done, result_we, div_zero, flags_we, quotient},
          16'h0000);
      rst_n = 1'b1;

      // R12: starts during a running division.
      run_op(8'h3C, 8'h05, 5'd0, 1'b0, 4'h2, 1'b0, 1'b0, 1'b1, 1'b1);
      run_op(8'h81, 8'hFD, 5'd0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1);
      run_op(8'h07, 8'h0E, 5'd0, 1'b0, 4'hF, 1'b1, 1'b0, 1'b1, 1'b1);

      // R11: most negative over minus one, full width.
      run_op(8'h80, 8'hFF, 5'd0, 1'b0, 4'h9, 1'b1, 1'b1, 1'b1, 1'b0);

      // R1 R3 R4 R5 R9: half width, every Y, low dividend and divisor.
      for (int sg = 0; sg < 2; sg++)
         for (int yy = 0; yy < 16; yy++)
            for (int a = 0; a < 16; a++)
               for (int d = 0; d < 16; d++)
                  run_op({4'(yy ^ 5), 4'(a)}, {4'(a ^ d), 4'(d)}, 5'd0, 1'b0,
                         4'(yy), 1'(sg), 1'b0, 1'(a ^ d), 1'b0);

      // R7 R11: full width, Y varies but must not matter.
      for (int sg = 0; sg < 2; sg++)
         for (int r = 0; r < 256; r++)
            for (int k = 0; k < 8; k++)
               run_op(8'(r), dlist[k], 5'd0, 1'b0, 4'(r ^ 10), 1'(sg), 1'b1,
                      1'(r >> 1), 1'b0);

      // R1: every immediate in both sizes; rs2 must not matter.
      for (int sg = 0; sg < 2; sg++)
         for (int wd = 0; wd < 2; wd++)
            for (int im = 0; im < 32; im++)
               for (int p = 0; p < 4; p++)
                  run_op((p == 0) ? 8'h00 : (p == 1) ? 8'h7F : (p == 2) ? 8'h80 : 8'hC5,
                         8'h55, 5'(im), 1'b1, 4'h3, 1'(sg), 1'(wd), 1'b1, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule